// File: doc/BRIEF.md
# Partitioned Vector Integer Execution Unit

This block executes one integer vector instruction at a time over several clock cycles. It holds a vector register file of 32 registers of 2048 bits each, organised as groups of 256 bits. Every cycle, four 64-bit lanes read one group from each of two source registers and compute one result group. The result is written into the same group of the destination register. Each lane is cut into independent sub-word slots of 8, 16, 32 or 64 bits, according to an element width chosen for each instruction. A narrower width therefore holds more elements per register and processes more of them per cycle.

An instruction is offered on a valid/ready issue port together with its operation, element width, vector length and a per-element flag mask. The unit stays busy while it steps through the groups covered by the clamped vector length, and it pulses a done flag once the last group has been written. Elements whose flag is clear, and elements at or beyond the vector length, keep their old destination value. A side port loads whole groups into the register file and reads them back, and this is how operands enter and results leave the block.

Top module: `vxu_top`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `iss_ready` is 1.
- R2: `iss_ready` is 1 exactly while `busy` is 0. An `iss_valid` asserted while busy starts nothing and produces no extra `done`.
- R3: An accepted instruction keeps `busy` high for exactly N cycles, where N = max(1, ceil(VLc*W/256)). `busy` rises in the cycle after acceptance. `done` is high for one cycle, in the cycle after the last busy cycle.
- R4: Opcode 0 (add) gives each element (a+b) mod 2^W. No carry passes from one element into its neighbour.
- R5: Opcode 1 (subtract) gives each element (a-b) mod 2^W, where a comes from source 1 and b from source 2.
- R6: Opcode 2 (min) and opcode 3 (max) compare the two elements as signed two's-complement values of W bits.
- R7: Width code 0, 1, 2 and 3 selects W = 8, 16, 32 and 64 bits. Element i occupies bits [i*W +: W] of the 2048-bit register, and group g covers bits [g*256 +: 256].
- R8: An element whose bit i in `iss_mask` is 0 keeps its previous destination value.
- R9: The vector length is clamped to 2048/W. Elements at index VLc or above keep their previous destination value.
- R10: A load writes the 256-bit group `ld_grp` of register `ld_reg` when the unit is idle. A load is ignored while `busy` is high. `rd_data` shows group `rd_grp` of `rd_reg` without any clock delay.
- R11: A vector length of 0 takes one busy cycle and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_valid | input | 1 | Instruction offered |
| iss_ready | output | 1 | Unit idle, offer is taken |
| iss_op | input | 2 | 0 add, 1 sub, 2 min, 3 max |
| iss_ew | input | 2 | Element width code |
| iss_vl | input | 9 | Vector length in elements |
| iss_vd | input | 5 | Destination register |
| iss_vs1 | input | 5 | First source register |
| iss_vs2 | input | 5 | Second source register |
| iss_mask | input | 256 | Per-element flag mask, bit i for element i |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Group load strobe |
| ld_reg | input | 5 | Register to load |
| ld_grp | input | 3 | Group to load |
| ld_data | input | 256 | Load data |
| rd_reg | input | 5 | Register to read |
| rd_grp | input | 3 | Group to read |
| rd_data | output | 256 | Read data |

## Verification
A group counter or last-group value that drifts shows up at the `done` pulse. There the number of busy cycles differs from N, or the next destination group is left stale. Both are visible at the readback in the cycle after the last write. A wrong slot width or a carry that leaks across slot boundaries corrupts the adjacent element in the first group written. A fault in the mask or length decode shows as protected elements that change value, and it is caught at the first completion whose mask or length leaves a gap.

// File: rtl/vxu_pkg.sv
package vxu_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_MIN = 2'd2,
      OP_MAX = 2'd3
   } vop_e;
endpackage

// File: rtl/vxu_regfile.sv
module vxu_regfile #(
   parameter int NREG = 32,
   parameter int NGRP = 8,
   parameter int GW   = 256,
   localparam int AW  = $clog2(NREG) + $clog2(NGRP),
   localparam int GB  = GW / 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [GW-1:0] wdata,
   input  logic [GB-1:0] wbe,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   input  logic [AW-1:0] raddr_c,
   output logic [GW-1:0] rdata_a,
   output logic [GW-1:0] rdata_b,
   output logic [GW-1:0] rdata_c
);
   localparam int DEPTH = NREG * NGRP;

   if ((1 << $clog2(NGRP)) != NGRP) begin : g_chk_grp
      $error("vxu_regfile: NGRP must be a power of two");
   end
   if (GW % 8 != 0) begin : g_chk_gw
      $error("vxu_regfile: GW must be a whole number of bytes");
   end

   logic [GW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int i = 0; i < GB; i++) begin
            if (wbe[i]) mem[waddr][i*8 +: 8] <= wdata[i*8 +: 8];
         end
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
   assign rdata_c = mem[raddr_c];
endmodule

// File: rtl/vxu_lane.sv
module vxu_lane #(
   parameter int LW   = 64,
   localparam int NEW = $clog2(LW / 8) + 1,
   localparam int EWW = $clog2(NEW)
) (
   input  logic [EWW-1:0] ew,
   input  logic [1:0]     op,
   input  logic [LW-1:0]  a,
   input  logic [LW-1:0]  b,
   output logic [LW-1:0]  y
);
   import vxu_pkg::*;

   if ((8 << (NEW - 1)) != LW) begin : g_chk_lw
      $error("vxu_lane: LW must be 8 times a power of two");
   end
   if (NEW < 2) begin : g_chk_new
      $error("vxu_lane: LW must allow at least two widths");
   end

   logic [LW-1:0] res [NEW];

   for (genvar k = 0; k < NEW; k++) begin : g_w
      localparam int W = 8 << k;
      localparam int S = LW / W;
      for (genvar s = 0; s < S; s++) begin : g_s
         logic [W-1:0] x, z, r;
         assign x = a[s*W +: W];
         assign z = b[s*W +: W];
         always_comb begin
            unique case (vop_e'(op))
               OP_ADD:  r = x + z;
               OP_SUB:  r = x - z;
               OP_MIN:  r = ($signed(x) < $signed(z)) ? x : z;
               default: r = ($signed(x) < $signed(z)) ? z : x;
            endcase
         end
         assign res[k][s*W +: W] = r;
      end
   end

   assign y = res[ew];
endmodule

// File: rtl/vxu_seq.sv
module vxu_seq #(
   parameter int NREG   = 32,
   parameter int LANES  = 4,
   parameter int LW     = 64,
   parameter int MAXE64 = 32,
   localparam int GW    = LANES * LW,
   localparam int GB    = GW / 8,
   localparam int NGRP  = MAXE64 / LANES,
   localparam int GRW   = $clog2(NGRP),
   localparam int RW    = $clog2(NREG),
   localparam int MAXE  = MAXE64 * (LW / 8),
   localparam int VLW   = $clog2(MAXE + 1),
   localparam int EIW   = $clog2(MAXE),
   localparam int EWW   = $clog2($clog2(LW / 8) + 1),
   localparam int BITW  = $clog2(MAXE * 8 + GW),
   localparam int GSH   = $clog2(GW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            iss_valid,
   output logic            iss_ready,
   input  logic [1:0]      iss_op,
   input  logic [EWW-1:0]  iss_ew,
   input  logic [VLW-1:0]  iss_vl,
   input  logic [RW-1:0]   iss_vd,
   input  logic [RW-1:0]   iss_vs1,
   input  logic [RW-1:0]   iss_vs2,
   input  logic [MAXE-1:0] iss_mask,
   output logic            busy,
   output logic            done,
   output logic [1:0]      cur_op,
   output logic [EWW-1:0]  cur_ew,
   output logic [RW-1:0]   cur_vd,
   output logic [RW-1:0]   cur_vs1,
   output logic [RW-1:0]   cur_vs2,
   output logic [GRW-1:0]  cur_grp,
   output logic [GB-1:0]   wbe
);
   if (NGRP < 2 || (1 << GRW) != NGRP) begin : g_chk_grp
      $error("vxu_seq: MAXE64/LANES must be a power of two of at least 2");
   end

   logic            busy_q, done_q;
   logic [VLW-1:0]  vl_q;
   logic [MAXE-1:0] mask_q;
   logic [GRW-1:0]  grp_q, last_q;

   // issue-time clamp and group count
   logic [VLW-1:0]  cap, vlc;
   logic [BITW-1:0] bits, ngr;
   logic [GRW-1:0]  last_d;

   always_comb begin
      cap    = VLW'(MAXE) >> iss_ew;
      vlc    = (iss_vl > cap) ? cap : iss_vl;
      bits   = BITW'(vlc) << (iss_ew + 3);
      ngr    = (bits + BITW'(GW - 1)) >> GSH;
      last_d = (ngr == '0) ? '0 : GRW'(ngr - 1'b1);
   end

   wire accept = iss_valid && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         vl_q    <= '0;
         mask_q  <= '0;
         grp_q   <= '0;
         last_q  <= '0;
         cur_op  <= '0;
         cur_ew  <= '0;
         cur_vd  <= '0;
         cur_vs1 <= '0;
         cur_vs2 <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            busy_q  <= 1'b1;
            vl_q    <= vlc;
            mask_q  <= iss_mask;
            grp_q   <= '0;
            last_q  <= last_d;
            cur_op  <= iss_op;
            cur_ew  <= iss_ew;
            cur_vd  <= iss_vd;
            cur_vs1 <= iss_vs1;
            cur_vs2 <= iss_vs2;
         end else if (busy_q) begin
            if (grp_q == last_q) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               grp_q <= grp_q + 1'b1;
            end
         end
      end
   end

   // byte enables: element index of each byte in the current group
   logic [EIW-1:0] elem;
   always_comb begin
      elem = '0;
      wbe  = '0;
      for (int b = 0; b < GB; b++) begin
         elem   = (EIW'(grp_q) * EIW'(GB) + EIW'(b)) >> cur_ew;
         wbe[b] = busy_q && (VLW'(elem) < vl_q) && mask_q[elem];
      end
   end

   assign busy      = busy_q;
   assign done      = done_q;
   assign iss_ready = !busy_q;
   assign cur_grp   = grp_q;

   assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready) |=> busy);
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   assert_grp_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cur_grp <= last_q));
   assert_hold_when_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && $past(busy)) |-> $stable(cur_vd));
   assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (wbe == '0));
endmodule

// File: rtl/vxu_top.sv
module vxu_top #(
   parameter int NREG   = 32,
   parameter int LANES  = 4,
   parameter int LW     = 64,
   parameter int MAXE64 = 32,
   localparam int GW    = LANES * LW,
   localparam int GB    = GW / 8,
   localparam int NGRP  = MAXE64 / LANES,
   localparam int GRW   = $clog2(NGRP),
   localparam int RW    = $clog2(NREG),
   localparam int MAXE  = MAXE64 * (LW / 8),
   localparam int VLW   = $clog2(MAXE + 1),
   localparam int EWW   = $clog2($clog2(LW / 8) + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            iss_valid,
   output logic            iss_ready,
   input  logic [1:0]      iss_op,
   input  logic [EWW-1:0]  iss_ew,
   input  logic [VLW-1:0]  iss_vl,
   input  logic [RW-1:0]   iss_vd,
   input  logic [RW-1:0]   iss_vs1,
   input  logic [RW-1:0]   iss_vs2,
   input  logic [MAXE-1:0] iss_mask,
   output logic            busy,
   output logic            done,
   input  logic            ld_en,
   input  logic [RW-1:0]   ld_reg,
   input  logic [GRW-1:0]  ld_grp,
   input  logic [GW-1:0]   ld_data,
   input  logic [RW-1:0]   rd_reg,
   input  logic [GRW-1:0]  rd_grp,
   output logic [GW-1:0]   rd_data
);
   if (MAXE64 % LANES != 0) begin : g_chk_lanes
      $error("vxu_top: MAXE64 must be a multiple of LANES");
   end

   logic [1:0]     s_op;
   logic [EWW-1:0] s_ew;
   logic [RW-1:0]  s_vd, s_vs1, s_vs2;
   logic [GRW-1:0] s_grp;
   logic [GB-1:0]  s_be;
   logic [GW-1:0]  opa, opb, alu_y;
   logic           rf_we;
   logic [RW+GRW-1:0] rf_waddr;
   logic [GW-1:0]  rf_wdata;
   logic [GB-1:0]  rf_wbe;

   vxu_seq #(.NREG(NREG), .LANES(LANES), .LW(LW), .MAXE64(MAXE64)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_op(iss_op), .iss_ew(iss_ew), .iss_vl(iss_vl),
      .iss_vd(iss_vd), .iss_vs1(iss_vs1), .iss_vs2(iss_vs2),
      .iss_mask(iss_mask),
      .busy(busy), .done(done),
      .cur_op(s_op), .cur_ew(s_ew), .cur_vd(s_vd),
      .cur_vs1(s_vs1), .cur_vs2(s_vs2), .cur_grp(s_grp),
      .wbe(s_be)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      vxu_lane #(.LW(LW)) u_lane (
         .ew(s_ew), .op(s_op),
         .a(opa[l*LW +: LW]), .b(opb[l*LW +: LW]),
         .y(alu_y[l*LW +: LW])
      );
   end

   // execution owns the write port while busy; loads only when idle
   always_comb begin
      rf_we    = busy || ld_en;
      rf_waddr = busy ? {s_vd, s_grp} : {ld_reg, ld_grp};
      rf_wdata = busy ? alu_y : ld_data;
      rf_wbe   = busy ? s_be : {GB{1'b1}};
   end

   vxu_regfile #(.NREG(NREG), .NGRP(NGRP), .GW(GW)) u_rf (
      .clk(clk),
      .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata), .wbe(rf_wbe),
      .raddr_a({s_vs1, s_grp}), .raddr_b({s_vs2, s_grp}),
      .raddr_c({rd_reg, rd_grp}),
      .rdata_a(opa), .rdata_b(opb), .rdata_c(rd_data)
   );

   assert_idle_write_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && !busy) |-> (rf_wbe == {GB{1'b1}}));
endmodule

// File: tb/sim_vxu_top.sv
module sim_vxu_top;
   localparam int RB = 2048;

   logic clk = 0, rst_n = 0;
   logic iss_valid = 0, iss_ready;
   logic [1:0] iss_op = 0, iss_ew = 0;
   logic [8:0] iss_vl = 0;
   logic [4:0] iss_vd = 0, iss_vs1 = 0, iss_vs2 = 0;
   logic [255:0] iss_mask = 0;
   logic busy, done;
   logic ld_en = 0;
   logic [4:0] ld_reg = 0, rd_reg = 0;
   logic [2:0] ld_grp = 0, rd_grp = 0;
   logic [255:0] ld_data = 0, rd_data;

   vxu_top u0 (.*);

   always #10 clk = ~clk;

   typedef struct {
      int           vd;
      logic [RB-1:0] val;
      int           cyc;
      string        tag;
   } exp_t;

   exp_t q[$];
   logic [RB-1:0] mreg [32];
   int checks = 0, errors = 0, bcnt = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s", msg);
      end
   endtask

   function automatic logic [RB-1:0] pat(input int seed);
      logic [RB-1:0] v;
      logic [31:0] s;
      s = seed;
      for (int i = 0; i < 64; i++) begin
         s = s * 32'd1664525 + 32'd1013904223;
         v[i*32 +: 32] = s;
      end
      return v;
   endfunction

   function automatic logic [RB-1:0] model(input int op, input int ew, input int vl,
         input logic [RB-1:0] a, input logic [RB-1:0] b, input logic [RB-1:0] d,
         input logic [255:0] mask);
      int w, cap, vlc;
      logic [63:0] m, x, z, r;
      logic [RB-1:0] mm, rr;
      w   = 8 << ew;
      cap = RB / w;
      vlc = (vl > cap) ? cap : vl;
      m   = (w == 64) ? '1 : ((64'd1 << w) - 1);
      for (int i = 0; i < vlc; i++) begin
         if (mask[i]) begin
            x = (a >> (i*w)) & m;
            z = (b >> (i*w)) & m;
            case (op)
               0: r = (x + z) & m;
               1: r = (x - z) & m;
               2: r = ($signed(x << (64-w)) < $signed(z << (64-w))) ? x : z;
               default: r = ($signed(x << (64-w)) < $signed(z << (64-w))) ? z : x;
            endcase
            mm = RB'(m) << (i*w);
            rr = RB'(r) << (i*w);
            d  = (d & ~mm) | rr;
         end
      end
      return d;
   endfunction

   task automatic load_reg(input int r, input logic [RB-1:0] v);
      for (int g = 0; g < 8; g++) begin
         @(negedge clk);
         ld_en = 1; ld_reg = 5'(r); ld_grp = 3'(g); ld_data = v[g*256 +: 256];
      end
      @(negedge clk);
      ld_en = 0;
      mreg[r] = v;
   endtask

   task automatic read_reg(input int r, output logic [RB-1:0] v);
      for (int g = 0; g < 8; g++) begin
         rd_reg = 5'(r); rd_grp = 3'(g);
         #1;
         v[g*256 +: 256] = rd_data;
      end
   endtask

   task automatic issue(input int op, input int ew, input int vl, input int vd,
         input int s1, input int s2, input logic [255:0] mask, input string tag);
      exp_t e;
      int w, cap, vlc, n;
      @(negedge clk);
      while (!iss_ready) @(negedge clk);
      w = 8 << ew; cap = RB / w; vlc = (vl > cap) ? cap : vl;
      n = (vlc * w + 255) / 256;
      if (n == 0) n = 1;
      e.vd = vd; e.cyc = n; e.tag = tag;
      e.val = model(op, ew, vl, mreg[s1], mreg[s2], mreg[vd], mask);
      mreg[vd] = e.val;
      q.push_back(e);
      iss_valid = 1; iss_op = 2'(op); iss_ew = 2'(ew); iss_vl = 9'(vl);
      iss_vd = 5'(vd); iss_vs1 = 5'(s1); iss_vs2 = 5'(s2); iss_mask = mask;
      @(negedge clk);
      iss_valid = 0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy || done || q.size() != 0) @(negedge clk);
   endtask

   // monitor: count busy cycles, compare destination at each completion
   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) bcnt++;
         if (done) begin
            if (q.size() == 0) begin
               chk(0, "R2 unexpected done with nothing issued (actual done=1, expected 0)");
            end else begin
               exp_t e;
               logic [RB-1:0] got;
               e = q.pop_front();
               chk(bcnt == e.cyc, $sformatf("R3 %s busy cycles actual %0d expected %0d",
                   e.tag, bcnt, e.cyc));
               read_reg(e.vd, got);
               if (got != e.val) begin
                  for (int g = 0; g < 8; g++)
                     if (got[g*256 +: 256] != e.val[g*256 +: 256]) begin
                        chk(0, $sformatf("%s group %0d actual %h expected %h", e.tag, g,
                            got[g*256 +: 256], e.val[g*256 +: 256]));
                        break;
                     end
               end else begin
                  chk(1, e.tag);
               end
            end
            bcnt = 0;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired (actual running, expected finished)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [RB-1:0] v;
      logic [255:0] alt16;
      for (int i = 0; i < 256; i++) alt16[i] = i[0];
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, $sformatf("R1 busy actual %0b expected 0", busy));
      chk(done == 0, $sformatf("R1 done actual %0b expected 0", done));
      chk(iss_ready == 1, $sformatf("R1 iss_ready actual %0b expected 1", iss_ready));
      rst_n = 1;

      for (int r = 0; r < 32; r++) load_reg(r, pat(r + 7));
      load_reg(3, '1);
      load_reg(4, {256{8'h01}});
      // R10 load and readback
      @(negedge clk);
      read_reg(5, v);
      chk(v == mreg[5], "R10 readback after load mismatch");

      issue(0, 3, 32, 10, 1, 2, '1, "R4 add w64 full");
      issue(0, 0, 256, 11, 3, 4, '1, "R4 R7 add w8 wrap no carry");
      issue(0, 3, 32, 12, 3, 4, '1, "R4 add w64 carry chain");
      issue(1, 1, 128, 13, 5, 6, '1, "R5 sub w16");
      issue(2, 2, 64, 14, 7, 8, '1, "R6 min w32 signed");
      issue(3, 0, 256, 15, 7, 8, '1, "R6 max w8 signed");
      issue(0, 1, 128, 16, 1, 2, alt16, "R8 masked add w16");
      issue(0, 2, 5, 17, 1, 2, '1, "R9 short vl w32");
      issue(1, 3, 400, 18, 1, 2, '1, "R9 clamped vl w64");
      issue(0, 0, 0, 19, 1, 2, '1, "R11 zero length");
      issue(0, 2, 64, 21, 7, 8, '1, "R4 add step");
      issue(2, 2, 64, 21, 21, 9, '1, "R6 min after add");
      issue(3, 1, 77, 22, 21, 5, ~alt16, "R7 R8 R9 max w16 partial");
      wait_idle();

      // R2/R10: offers and loads while busy are ignored
      issue(0, 3, 32, 23, 1, 2, '1, "R2 long add");
      @(negedge clk);
      chk(iss_ready == 0, $sformatf("R2 iss_ready while busy actual %0b expected 0", iss_ready));
      iss_valid = 1; iss_op = 1; iss_vd = 24; iss_vs1 = 1; iss_vs2 = 2; iss_vl = 32; iss_ew = 3;
      ld_en = 1; ld_reg = 20; ld_grp = 0; ld_data = '0;
      @(negedge clk);
      @(negedge clk);
      iss_valid = 0; ld_en = 0;
      wait_idle();
      repeat (2) @(negedge clk);
      chk(q.size() == 0, "R2 queue not empty");
      read_reg(20, v);
      chk(v == mreg[20], $sformatf("R10 load during busy changed r20 group0 actual %h expected %h",
          v[255:0], mreg[20][255:0]));
      read_reg(24, v);
      chk(v == mreg[24], $sformatf("R2 ignored offer changed r24 group0 actual %h expected %h",
          v[255:0], mreg[24][255:0]));

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule